// File: doc/BRIEF.md
# Backplane Slave Window Decoder

This block decodes host accesses to a slave card that owns a 256 KB window on a VME-style backplane. Static switch inputs set the window base, and one mode switch picks between 24-bit and 32-bit addressing. If the upper address bits match the switches, the low 18 bits are mapped onto nine resources. These are the two buffers, the peripheral controller register group, the DMA address and count registers, the two control/status registers and the two interrupt vector registers. Each resource has its own one-hot select line.

The block also holds the two 8-bit interrupt vector registers. It gates the interrupt requests of two sources, a storage-side source on the lower level and a network-side source on the higher level. During an interrupt acknowledge cycle it claims the cycle and returns the vector that belongs to the acknowledged level. Every accepted access or claimed acknowledge is answered with a one-cycle acknowledge pulse on the following clock.

Top module: `slvdec_top`

## Requirements
- R1: With `sw_mode_open` = 1 (24-bit mode) only address bits [23:18] are compared with the switches, and bits [31:24] are ignored. With `sw_mode_open` = 0 (32-bit mode) bits [31:18] are all compared.
- R2: Switch `sw_base[i]` governs address bit 18+i. A 1 (open) requires that bit to be 1, and a 0 (closed) requires it to be 0. An address that differs in any compared bit asserts no select and no miss flag.
- R3: Inside the window, the offset `addr[17:0]` drives `sel` one-hot with this bit order: bit0 0x00000–0x0FFFF, bit1 0x20000–0x3FFFF, bit2 0x10000–0x10007, bit3 0x1000A–0x1000B, bit4 0x1000E–0x1000F, bit5 0x1001A–0x1001B, bit6 0x1FF02–0x1FF03, bit7 0x1001E, bit8 0x1FF12.
- R4: An in-window access whose offset maps to no resource leaves `sel` at zero and raises `decode_miss`.
- R5: The lower-level vector register (offset 0x1001E) and the higher-level vector register (offset 0x1FF12) reset to 0x0F. A write access loads them from `wdata`, and a read access returns them on `vec_data`. Writes to any other resource leave them unchanged.
- R6: `irq_lo_req` is high exactly when `lo_irq_flag` and `lo_irq_en` are both high. `irq_hi_req` is high exactly when `hi_irq_flag` and `hi_irq_en` are both high.
- R7: While `iack` is high with `iack_level` = 2, the cycle is claimed only if `irq_lo_req` is high. With `iack_level` = 3, it is claimed only if `irq_hi_req` is high. Any other nonzero level is never claimed. When a cycle is claimed, `vec_data` carries the vector of that level.
- R8: With `iack_level` = 0 (generic acknowledge), the cycle is claimed if either request is pending. The higher-level vector is returned whenever `irq_hi_req` is high.
- R9: `ack` is high in the cycle after each cycle with an accepted access (in window, mapped) or a claimed acknowledge. It stays low after a miss, an out-of-window access or an unclaimed acknowledge.
- R10: While `iack` is high, `sel` and `decode_miss` stay low and writes have no effect on the vector registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_mode_open | input | 1 | Mode switch, 1 = open = 24-bit addressing |
| sw_base | input | 14 | Base switches for address bits 31:18, 1 = open = bit must be 1 |
| addr | input | 32 | Host byte address |
| addr_valid | input | 1 | Host access in progress |
| wr_en | input | 1 | Access is a write |
| wdata | input | 8 | Write data for vector registers |
| iack | input | 1 | Interrupt acknowledge cycle |
| iack_level | input | 3 | Acknowledged level, 0 = generic |
| lo_irq_flag | input | 1 | Lower-level source interrupt flag |
| lo_irq_en | input | 1 | Lower-level source interrupt enable |
| hi_irq_flag | input | 1 | Higher-level source interrupt flag |
| hi_irq_en | input | 1 | Higher-level source interrupt enable |
| sel | output | 9 | One-hot resource select |
| decode_miss | output | 1 | In-window access to an unmapped offset |
| ack | output | 1 | One-cycle access acknowledge |
| irq_lo_req | output | 1 | Lower-level interrupt request |
| irq_hi_req | output | 1 | Higher-level interrupt request |
| iack_claim | output | 1 | Acknowledge cycle claimed by this block |
| vec_data | output | 8 | Vector on claim or vector register read, else 0 |

## Verification
On every cycle, the assertions check that `sel` is never more than one-hot and that a miss never coincides with a select. They also check that nothing is selected during an acknowledge, that a claim always has a pending request behind it, that `ack` only follows an access or acknowledge cycle, and that each vector register holds its value unless it is written. The address map itself can only be shown by the bench's scenarios. That covers the exact offset boundaries, the inverted switch sense, the mode-dependent compare width, the vector values returned per level and the level-3 preference on a generic acknowledge.

// File: rtl/slvdec_pkg.sv
package slvdec_pkg;
   localparam int OFF_W   = 18;
   localparam int NUM_RES = 9;

   typedef enum logic [3:0] {
      RES_SBUF, RES_EBUF, RES_SBC, RES_DADR, RES_DCNT,
      RES_SCSR, RES_ECSR, RES_VEC_LO, RES_VEC_HI
   } res_e;

   localparam logic [OFF_W-1:0] RES_BASE [NUM_RES] = '{
      18'h00000, 18'h20000, 18'h10000, 18'h1000A, 18'h1000E,
      18'h1001A, 18'h1FF02, 18'h1001E, 18'h1FF12
   };
   localparam int RES_LG [NUM_RES] = '{16, 17, 3, 1, 1, 1, 1, 0, 0};
endpackage

// File: rtl/slvdec_base_match.sv
module slvdec_base_match #(
   parameter int ADDR_W     = 32,
   parameter int BASE_LSB   = 18,
   parameter int NARROW_MSB = 23,
   localparam int SW_W      = ADDR_W - BASE_LSB
) (
   input  logic [SW_W-1:0] addr_hi,
   input  logic [SW_W-1:0] sw_base,
   input  logic            narrow,
   output logic            match
);
   logic [SW_W-1:0] care;
   logic [SW_W-1:0] agree;

   for (genvar i = 0; i < SW_W; i++) begin : g_bit
      if (BASE_LSB + i <= NARROW_MSB) begin : g_always
         assign care[i] = 1'b1;
      end else begin : g_wide_only
         assign care[i] = ~narrow;
      end
      assign agree[i] = (addr_hi[i] == sw_base[i]) | ~care[i];
   end

   assign match = &agree;
endmodule

// File: rtl/slvdec_offset_map.sv
module slvdec_offset_map
   import slvdec_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_window,
   input  logic [OFF_W-1:0]   offset,
   output logic [NUM_RES-1:0] sel,
   output logic               miss
);
   logic [NUM_RES-1:0] hit;

   for (genvar i = 0; i < NUM_RES; i++) begin : g_res
      localparam int LG = RES_LG[i];
      if ((RES_BASE[i] & ((18'd1 << LG) - 18'd1)) != '0) begin : g_misaligned
         $error("resource %0d base not aligned to its size", i);
      end
      assign hit[i] = (offset >> LG) == (RES_BASE[i] >> LG);
   end

   assign sel  = in_window ? hit : '0;
   assign miss = in_window & ~(|hit);

   a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   a_r4_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (sel == '0));
endmodule

// File: rtl/slvdec_vector_regs.sv
module slvdec_vector_regs #(
   parameter int VEC_W                  = 8,
   parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F,
   parameter int LVL_W                  = 3,
   parameter int LO_LEVEL               = 2,
   parameter int HI_LEVEL               = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic             rd_lo,
   input  logic             rd_hi,
   input  logic [VEC_W-1:0] wdata,
   input  logic             lo_flag,
   input  logic             lo_en,
   input  logic             hi_flag,
   input  logic             hi_en,
   input  logic             iack,
   input  logic [LVL_W-1:0] iack_level,
   output logic             irq_lo,
   output logic             irq_hi,
   output logic             claim,
   output logic [VEC_W-1:0] vec_data
);
   logic [VEC_W-1:0] vec_lo_q, vec_hi_q;
   logic             generic, lvl_lo, lvl_hi, pick_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_lo_q <= VEC_RESET;
         vec_hi_q <= VEC_RESET;
      end else begin
         if (wr_lo) vec_lo_q <= wdata;
         if (wr_hi) vec_hi_q <= wdata;
      end
   end

   assign irq_lo  = lo_flag & lo_en;
   assign irq_hi  = hi_flag & hi_en;
   assign generic = (iack_level == '0);
   assign lvl_lo  = (iack_level == LVL_W'(LO_LEVEL));
   assign lvl_hi  = (iack_level == LVL_W'(HI_LEVEL));
   assign pick_hi = irq_hi & (lvl_hi | generic);
   assign claim   = iack & (pick_hi | (irq_lo & (lvl_lo | generic)));

   always_comb begin
      if (claim)      vec_data = pick_hi ? vec_hi_q : vec_lo_q;
      else if (rd_lo) vec_data = vec_lo_q;
      else if (rd_hi) vec_data = vec_hi_q;
      else            vec_data = '0;
   end

   a_r7_claim_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (irq_lo | irq_hi));
   a_r5_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo |=> $stable(vec_lo_q));
   a_r5_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hi |=> $stable(vec_hi_q));
endmodule

// File: rtl/slvdec_top.sv
module slvdec_top
   import slvdec_pkg::*;
#(
   parameter int ADDR_W                  = 32,
   parameter int NARROW_MSB              = 23,
   parameter int VEC_W                   = 8,
   parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F,
   parameter int LVL_W                   = 3,
   parameter int LO_LEVEL                = 2,
   parameter int HI_LEVEL                = 3,
   localparam int SW_W                   = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_mode_open,
   input  logic [SW_W-1:0]    sw_base,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               addr_valid,
   input  logic               wr_en,
   input  logic [VEC_W-1:0]   wdata,
   input  logic               iack,
   input  logic [LVL_W-1:0]   iack_level,
   input  logic               lo_irq_flag,
   input  logic               lo_irq_en,
   input  logic               hi_irq_flag,
   input  logic               hi_irq_en,
   output logic [NUM_RES-1:0] sel,
   output logic               decode_miss,
   output logic               ack,
   output logic               irq_lo_req,
   output logic               irq_hi_req,
   output logic               iack_claim,
   output logic [VEC_W-1:0]   vec_data
);
   if (NARROW_MSB < OFF_W || NARROW_MSB >= ADDR_W) begin : g_bad_narrow
      $error("NARROW_MSB must lie inside the base field");
   end
   if (LO_LEVEL == HI_LEVEL || LO_LEVEL == 0 || HI_LEVEL == 0 ||
       HI_LEVEL >= (1 << LVL_W) || LO_LEVEL >= (1 << LVL_W)) begin : g_bad_level
      $error("interrupt levels must be distinct, nonzero and fit LVL_W");
   end

   logic match, in_window, accept, ack_q;

   slvdec_base_match #(
      .ADDR_W(ADDR_W), .BASE_LSB(OFF_W), .NARROW_MSB(NARROW_MSB)
   ) u_match (
      .addr_hi (addr[ADDR_W-1:OFF_W]),
      .sw_base (sw_base),
      .narrow  (sw_mode_open),
      .match   (match)
   );

   assign in_window = addr_valid & ~iack & match;

   slvdec_offset_map u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_window (in_window),
      .offset    (addr[OFF_W-1:0]),
      .sel       (sel),
      .miss      (decode_miss)
   );

   assign accept = |sel;

   slvdec_vector_regs #(
      .VEC_W(VEC_W), .VEC_RESET(VEC_RESET), .LVL_W(LVL_W),
      .LO_LEVEL(LO_LEVEL), .HI_LEVEL(HI_LEVEL)
   ) u_vec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (sel[int'(RES_VEC_LO)] & wr_en),
      .wr_hi      (sel[int'(RES_VEC_HI)] & wr_en),
      .rd_lo      (sel[int'(RES_VEC_LO)] & ~wr_en),
      .rd_hi      (sel[int'(RES_VEC_HI)] & ~wr_en),
      .wdata      (wdata),
      .lo_flag    (lo_irq_flag),
      .lo_en      (lo_irq_en),
      .hi_flag    (hi_irq_flag),
      .hi_en      (hi_irq_en),
      .iack       (iack),
      .iack_level (iack_level),
      .irq_lo     (irq_lo_req),
      .irq_hi     (irq_hi_req),
      .claim      (iack_claim),
      .vec_data   (vec_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= accept | iack_claim;
   end
   assign ack = ack_q;

   a_r10_quiet_in_iack: assert property (@(posedge clk) disable iff (!rst_n)
      iack |-> (sel == '0 && !decode_miss));
   a_r9_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(addr_valid | iack));
endmodule

// File: tb/slvdec_top_tb_top.sv
module slvdec_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_mode_open = 1'b0;
   logic [13:0] sw_base = 14'h2930;
   logic [31:0] addr = '0;
   logic        addr_valid = 1'b0, wr_en = 1'b0, iack = 1'b0;
   logic [7:0]  wdata = '0;
   logic [2:0]  iack_level = '0;
   logic        lo_irq_flag = 1'b0, lo_irq_en = 1'b0, hi_irq_flag = 1'b0, hi_irq_en = 1'b0;
   logic [8:0]  sel;
   logic        decode_miss, ack, irq_lo_req, irq_hi_req, iack_claim;
   logic [7:0]  vec_data;
   int          n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   slvdec_top dut_i (
      .clk(clk), .rst_n(rst_n), .sw_mode_open(sw_mode_open), .sw_base(sw_base),
      .addr(addr), .addr_valid(addr_valid), .wr_en(wr_en), .wdata(wdata),
      .iack(iack), .iack_level(iack_level),
      .lo_irq_flag(lo_irq_flag), .lo_irq_en(lo_irq_en),
      .hi_irq_flag(hi_irq_flag), .hi_irq_en(hi_irq_en),
      .sel(sel), .decode_miss(decode_miss), .ack(ack),
      .irq_lo_req(irq_lo_req), .irq_hi_req(irq_hi_req),
      .iack_claim(iack_claim), .vec_data(vec_data)
   );

   // {mode_open, addr, expected sel, expected miss}; base switches 14'h2930
   localparam int NV = 20;
   localparam logic [42:0] VECS [NV] = '{
      {1'b0, 32'hA4C00000, 9'h001, 1'b0},   // R3 scsi buffer low edge
      {1'b0, 32'hA4C0FFFF, 9'h001, 1'b0},   // R3 scsi buffer high edge
      {1'b0, 32'hA4C20000, 9'h002, 1'b0},   // R3 net buffer low edge
      {1'b0, 32'hA4C3FFFF, 9'h002, 1'b0},   // R3 net buffer high edge
      {1'b0, 32'hA4C10003, 9'h004, 1'b0},   // R3 controller regs
      {1'b0, 32'hA4C10007, 9'h004, 1'b0},
      {1'b0, 32'hA4C1000B, 9'h008, 1'b0},   // R3 dma address
      {1'b0, 32'hA4C1000E, 9'h010, 1'b0},   // R3 dma count
      {1'b0, 32'hA4C1001A, 9'h020, 1'b0},   // R3 scsi csr
      {1'b0, 32'hA4C1FF03, 9'h040, 1'b0},   // R3 net csr
      {1'b0, 32'hA4C1001E, 9'h080, 1'b0},   // R3 lo vector
      {1'b0, 32'hA4C1FF12, 9'h100, 1'b0},   // R3 hi vector
      {1'b0, 32'hA4C10008, 9'h000, 1'b1},   // R4 hole
      {1'b0, 32'hA4C1001F, 9'h000, 1'b1},   // R4 next to lo vector
      {1'b0, 32'hA5C00000, 9'h000, 1'b0},   // R2 bit 24 differs
      {1'b0, 32'h24C00000, 9'h000, 1'b0},   // R2 bit 31 differs
      {1'b1, 32'h00C10000, 9'h004, 1'b0},   // R1 narrow ignores upper bits
      {1'b1, 32'hFFC20000, 9'h002, 1'b0},   // R1 narrow
      {1'b1, 32'h00D00000, 9'h000, 1'b0},   // R1 bit 20 still compared
      {1'b1, 32'h00C1FF04, 9'h000, 1'b1}    // R4 narrow miss
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at negedge, check combinational outputs, then the ack one edge later
   task automatic access(input logic mode, input logic [31:0] a, input logic wr,
                         input logic [7:0] d, input logic exp_ack);
      @(negedge clk);
      sw_mode_open = mode; addr = a; wr_en = wr; wdata = d; addr_valid = 1'b1;
      @(posedge clk); #1;
      chk("R9 ack", {31'b0, ack}, {31'b0, exp_ack});
      @(negedge clk);
      addr_valid = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd_vec(input logic [31:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      sw_mode_open = 1'b0; addr = a; wr_en = 1'b0; addr_valid = 1'b1;
      #1 chk(req, {24'b0, vec_data}, {24'b0, exp});
      @(negedge clk);
      addr_valid = 1'b0;
   endtask

   task automatic do_iack(input logic [2:0] lvl, input logic exp_claim,
                          input logic [7:0] exp_vec, input string req);
      @(negedge clk);
      iack = 1'b1; iack_level = lvl;
      #1;
      chk(req, {31'b0, iack_claim}, {31'b0, exp_claim});
      if (exp_claim) chk(req, {24'b0, vec_data}, {24'b0, exp_vec});
      @(posedge clk); #1;
      chk("R9 ack after acknowledge", {31'b0, ack}, {31'b0, exp_claim});
      @(negedge clk);
      iack = 1'b0; iack_level = '0;
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset ack", {31'b0, ack}, 32'd0);
      chk("R3 reset sel", {23'b0, sel}, 32'd0);
      @(negedge clk) rst_n = 1'b1;

      // R5 reset values
      rd_vec(32'hA4C1001E, 8'h0F, "R5 lo reset");
      rd_vec(32'hA4C1FF12, 8'h0F, "R5 hi reset");

      // table walk: R1 R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         sw_mode_open = VECS[i][42]; addr = VECS[i][41:10]; addr_valid = 1'b1; wr_en = 1'b0;
         #1;
         chk("R1/R2/R3 sel", {23'b0, sel}, {23'b0, VECS[i][9:1]});
         chk("R4 miss", {31'b0, decode_miss}, {31'b0, VECS[i][0]});
         @(posedge clk); #1;
         chk("R9 ack", {31'b0, ack}, {31'b0, (VECS[i][9:1] != 9'h0)});
         @(negedge clk);
         addr_valid = 1'b0;
      end

      // R5 writes, other resources leave vectors alone
      access(1'b0, 32'hA4C1001E, 1'b1, 8'h5A, 1'b1);
      access(1'b0, 32'hA4C1FF12, 1'b1, 8'hC3, 1'b1);
      access(1'b0, 32'hA4C1001A, 1'b1, 8'h77, 1'b1);
      access(1'b0, 32'hA4C10008, 1'b1, 8'h66, 1'b0);
      access(1'b0, 32'hA5C1001E, 1'b1, 8'h99, 1'b0);
      rd_vec(32'hA4C1001E, 8'h5A, "R5 lo written");
      rd_vec(32'hA4C1FF12, 8'hC3, "R5 hi written");

      // R10 write during acknowledge ignored, no select
      @(negedge clk);
      iack = 1'b1; iack_level = 3'd5; addr = 32'hA4C1001E; addr_valid = 1'b1; wr_en = 1'b1; wdata = 8'h11;
      #1;
      chk("R10 sel in iack", {23'b0, sel}, 32'd0);
      chk("R10 miss in iack", {31'b0, decode_miss}, 32'd0);
      @(negedge clk);
      iack = 1'b0; addr_valid = 1'b0; wr_en = 1'b0;
      rd_vec(32'hA4C1001E, 8'h5A, "R10 lo kept");

      // R6 gating
      @(negedge clk);
      lo_irq_flag = 1'b1; lo_irq_en = 1'b0; hi_irq_flag = 1'b0; hi_irq_en = 1'b1;
      #1;
      chk("R6 lo gated", {31'b0, irq_lo_req}, 32'd0);
      chk("R6 hi gated", {31'b0, irq_hi_req}, 32'd0);
      do_iack(3'd0, 1'b0, 8'h00, "R8 generic none pending");
      @(negedge clk) lo_irq_en = 1'b1;
      #1 chk("R6 lo raised", {31'b0, irq_lo_req}, 32'd1);

      // R7 specific levels
      do_iack(3'd2, 1'b1, 8'h5A, "R7 lo claim");
      do_iack(3'd3, 1'b0, 8'h00, "R7 hi not pending");
      do_iack(3'd1, 1'b0, 8'h00, "R7 foreign level");
      do_iack(3'd0, 1'b1, 8'h5A, "R8 generic lo only");

      @(negedge clk) hi_irq_flag = 1'b1;
      #1 chk("R6 hi raised", {31'b0, irq_hi_req}, 32'd1);
      do_iack(3'd3, 1'b1, 8'hC3, "R7 hi claim");
      do_iack(3'd2, 1'b1, 8'h5A, "R7 lo claim with both");
      do_iack(3'd0, 1'b1, 8'hC3, "R8 generic prefers hi");

      @(negedge clk);
      lo_irq_flag = 1'b0;
      #1 chk("R6 lo dropped", {31'b0, irq_lo_req}, 32'd0);
      do_iack(3'd2, 1'b0, 8'h00, "R7 lo not pending");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule